// File: doc/BRIEF.md
# Load/Store Multiple Beat Sequencer

This block takes a single request to move a group of registers to or from memory and breaks it into a run of memory access beats, one per clock cycle. A request carries a word-aligned 32-bit base address, a 16-bit register mask, a load/store select and a flag that says whether the first loaded value may be forwarded straight to the following operation. Each beat presents an address, one or two register indices and a size flag that marks a word or a doubleword transfer.

Two registers share one beat whenever the current address sits on an 8-byte boundary and at least two registers remain. A request whose base is only word aligned therefore spends its first beat on a lone word to reach the boundary, and pairs registers after that. For loads the block also raises a one-cycle pulse at the point where the first loaded register can be consumed. Data movement, base update, descending address modes and faults belong to neighbouring logic.

Top module: `lsm_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, busy_o, beat_valid_o, done_o, err_o and first_ready_o are all low.
- R2: A beat is a doubleword (beat_dword_o = 1) only when its address has bits [2:0] equal to zero and two or more registers remain. It then carries the two lowest-numbered remaining registers, the lower in beat_reg0_o and the higher in beat_reg1_o. A single-word beat carries the lowest remaining register in beat_reg0_o and drives beat_reg1_o to 0.
- R3: With a base whose bit 2 is zero, a request of n registers (1 to 16) issues ceil(n/2) beats.
- R4: With a base whose bit 2 is one, a request of n registers issues floor(n/2)+1 beats, and the first beat is a single word for the lowest-numbered register at the base address.
- R5: The first beat address is the base address. Each later address is the previous one plus 4 after a word beat, or plus 8 after a doubleword beat.
- R6: A store request produces exactly the same beat sequence as a load with the same base and mask. beat_load_o is 1 on every beat of a load and 0 on every beat of a store.
- R7: A request accepted at a clock edge issues its first beat in the next cycle. busy_o and beat_valid_o are high on exactly the beat cycles. done_o is high for one cycle, in the cycle right after the last beat.
- R8: A start pulse that arrives while busy_o is high has no effect on the beats in progress.
- R9: An all-zero mask issues no beats. It raises done_o and err_o together for one cycle, in the cycle right after the start edge.
- R10: For a load, first_ready_o pulses for one cycle 2 cycles after the first beat when the forward flag was set at start, and 3 cycles after it otherwise. Stores and zero-mask requests never pulse it.
- R11: A request for a single register issues one word beat, whatever the alignment of the base.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request strobe, taken when not busy |
| base_addr_i | input | 32 | Word-aligned start address |
| reg_mask_i | input | 16 | One bit per register to transfer |
| is_load_i | input | 1 | 1 for load, 0 for store |
| fwd_ok_i | input | 1 | First loaded value may be forwarded directly |
| busy_o | output | 1 | High on every beat cycle of a request |
| beat_valid_o | output | 1 | A beat is presented this cycle |
| beat_addr_o | output | 32 | Address of the current beat |
| beat_dword_o | output | 1 | 1 when the beat moves a doubleword |
| beat_reg0_o | output | 4 | Register carried in the lower word |
| beat_reg1_o | output | 4 | Register carried in the upper word of a doubleword beat |
| beat_load_o | output | 1 | Direction of the current beat |
| done_o | output | 1 | One-cycle pulse after the last beat |
| err_o | output | 1 | One-cycle pulse marking an empty mask |
| first_ready_o | output | 1 | One-cycle pulse when the first loaded register is usable |

## Verification
The bench goes after the alignment corners: a base with bit 2 set must cost one extra word beat and then switch to paired beats. A design that paired from the start would put doublewords on misaligned addresses, and one that never paired would take n beats. Sparse masks with gaps check that pairs take the next two set bits rather than adjacent indices, and that a lone last register goes out as a word. Start pulses with unrelated masks are fired during busy cycles, and a sequencer that accepted them would show altered addresses or registers. The first-ready pulse is checked on both latencies and stays silent for stores and empty masks, and one-register requests catch off-by-one beat counting.

// File: rtl/lsm_pkg.sv
// Shared definitions for the load/store multiple beat sequencer.
// Assumes byte addressing with 4-byte words.
package lsm_pkg;
    localparam int WORD_BYTES = 4;
    localparam int DWORD_BYTES = 2 * WORD_BYTES;

    // Transfer size carried by one beat.
    typedef enum logic {
        SZ_WORD  = 1'b0,
        SZ_DWORD = 1'b1
    } beat_size_e;
endpackage

// File: rtl/lsm_lowbit.sv
// Finds the lowest set bit of a mask.
// Assumes nothing about the mask; found_o is low for an all-zero mask,
// in which case idx_o is zero.
module lsm_lowbit #(
    parameter int NREG = 16,
    localparam int IDXW = $clog2(NREG)
) (
    input  logic [NREG-1:0] mask_i,
    output logic [IDXW-1:0] idx_o,
    output logic            found_o
);
    // Scan from the top so the lowest set bit is written last.
    always_comb begin
        idx_o   = '0;
        found_o = 1'b0;
        for (int i = NREG - 1; i >= 0; i--) begin
            if (mask_i[i]) begin
                idx_o   = IDXW'(i);
                found_o = 1'b1;
            end
        end
    end
endmodule

// File: rtl/lsm_ready_pipe.sv
// Delays a fire strobe by one of two latencies to flag when the first
// loaded register becomes usable. Overlapping requests are allowed:
// each one sets its own bit in the delay line.
// Assumes 1 <= LAT_FAST <= LAT_SLOW.
module lsm_ready_pipe #(
    parameter int LAT_FAST = 2,
    parameter int LAT_SLOW = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    input  logic fast_i,
    output logic ready_o
);
    localparam int W = LAT_SLOW;

    logic [W-1:0] line_q;
    logic [W-1:0] ins;

    // Pick the insertion slot from the selected latency.
    always_comb begin
        ins = '0;
        if (fire_i) begin
            ins = fast_i ? (W'(1) << (LAT_FAST - 1)) : (W'(1) << (LAT_SLOW - 1));
        end
    end

    // Shift the delay line toward bit 0 each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= '0;
        end else begin
            line_q <= (line_q >> 1) | ins;
        end
    end

    assign ready_o = line_q[0];
endmodule

// File: rtl/lsm_seq.sv
// Load/store multiple beat sequencer.
// Accepts one request when idle and issues one beat per cycle until every
// register in the mask has been sent. A beat pairs two registers whenever
// its address is 8-byte aligned and two or more registers remain.
// Assumes base_addr_i is word aligned; bits below the word are carried as given.
module lsm_seq #(
    parameter int AW       = 32,
    parameter int NREG     = 16,
    parameter int LAT_FAST = 2,
    parameter int LAT_SLOW = 3,
    localparam int IDXW    = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [AW-1:0]   base_addr_i,
    input  logic [NREG-1:0] reg_mask_i,
    input  logic            is_load_i,
    input  logic            fwd_ok_i,
    output logic            busy_o,
    output logic            beat_valid_o,
    output logic [AW-1:0]   beat_addr_o,
    output logic            beat_dword_o,
    output logic [IDXW-1:0] beat_reg0_o,
    output logic [IDXW-1:0] beat_reg1_o,
    output logic            beat_load_o,
    output logic            done_o,
    output logic            err_o,
    output logic            first_ready_o
);
    import lsm_pkg::*;

    localparam int DW_LSB = $clog2(DWORD_BYTES);
    localparam logic [NREG-1:0] ONE = NREG'(1);

    logic [NREG-1:0] rem_q;
    logic [AW-1:0]   addr_q;
    logic            load_q;
    logic            fwd_q;
    logic            first_q;
    logic            done_q;
    logic            err_q;

    logic [IDXW-1:0] idx0, idx1;
    logic            has0, has1;
    logic [NREG-1:0] rest;
    logic [NREG-1:0] clear;
    logic [NREG-1:0] rem_next;
    logic            aligned;
    beat_size_e      size;
    logic            busy;
    logic            take;

    // Lowest remaining register, then the lowest of what is left after it.
    lsm_lowbit #(.NREG(NREG)) u_pick0 (
        .mask_i  (rem_q),
        .idx_o   (idx0),
        .found_o (has0)
    );

    assign rest = rem_q & ~(ONE << idx0);

    lsm_lowbit #(.NREG(NREG)) u_pick1 (
        .mask_i  (rest),
        .idx_o   (idx1),
        .found_o (has1)
    );

    assign busy    = has0;
    assign aligned = (addr_q[DW_LSB-1:0] == '0);
    assign take    = start_i && !busy;

    // Choose the beat size and the registers this beat retires.
    always_comb begin
        size  = (aligned && has1) ? SZ_DWORD : SZ_WORD;
        clear = ONE << idx0;
        if (size == SZ_DWORD) begin
            clear = clear | (ONE << idx1);
        end
        rem_next = rem_q & ~clear;
    end

    // Request capture, beat stepping and completion flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q   <= '0;
            addr_q  <= '0;
            load_q  <= 1'b0;
            fwd_q   <= 1'b0;
            first_q <= 1'b0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            if (take) begin
                rem_q   <= reg_mask_i;
                addr_q  <= base_addr_i;
                load_q  <= is_load_i;
                fwd_q   <= fwd_ok_i;
                first_q <= 1'b1;
                if (reg_mask_i == '0) begin
                    done_q <= 1'b1;
                    err_q  <= 1'b1;
                end
            end else if (busy) begin
                rem_q   <= rem_next;
                addr_q  <= addr_q + ((size == SZ_DWORD) ? AW'(DWORD_BYTES) : AW'(WORD_BYTES));
                first_q <= 1'b0;
                if (rem_next == '0) begin
                    done_q <= 1'b1;
                end
            end
        end
    end

    lsm_ready_pipe #(.LAT_FAST(LAT_FAST), .LAT_SLOW(LAT_SLOW)) u_ready (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire_i  (busy && first_q && load_q),
        .fast_i  (fwd_q),
        .ready_o (first_ready_o)
    );

    assign busy_o       = busy;
    assign beat_valid_o = busy;
    assign beat_addr_o  = addr_q;
    assign beat_dword_o = (size == SZ_DWORD);
    assign beat_reg0_o  = idx0;
    assign beat_reg1_o  = (size == SZ_DWORD) ? idx1 : '0;
    assign beat_load_o  = load_q;
    assign done_o       = done_q;
    assign err_o        = err_q;
endmodule

// File: rtl/lsm_seq_chk.sv
// Property checker for lsm_seq, attached through bind.
// Assumes the default word size of 4 bytes.
module lsm_seq_chk #(
    parameter int AW   = 32,
    parameter int IDXW = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start_i,
    input logic            busy_o,
    input logic [AW-1:0]   beat_addr_o,
    input logic            beat_dword_o,
    input logic [IDXW-1:0] beat_reg0_o,
    input logic [IDXW-1:0] beat_reg1_o,
    input logic            beat_load_o,
    input logic            done_o,
    input logic            err_o
);
    AST_DWORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && beat_dword_o) |-> (beat_addr_o[2:0] == 3'b000)); // R2

    AST_PAIR_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && beat_dword_o) |-> (beat_reg1_o > beat_reg0_o)); // R2

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |->
        (beat_addr_o == $past(beat_addr_o) + ($past(beat_dword_o) ? AW'(8) : AW'(4)))); // R5

    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o); // R7

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R7

    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (done_o && !busy_o)); // R9

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> (!busy_o || (beat_load_o == $past(beat_load_o)))); // R8
endmodule

bind lsm_seq lsm_seq_chk #(.AW(AW), .IDXW(IDXW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .busy_o       (busy_o),
    .beat_addr_o  (beat_addr_o),
    .beat_dword_o (beat_dword_o),
    .beat_reg0_o  (beat_reg0_o),
    .beat_reg1_o  (beat_reg1_o),
    .beat_load_o  (beat_load_o),
    .done_o       (done_o),
    .err_o        (err_o)
);

// File: tb/lsm_seq_tb.sv
// Bench for lsm_seq: directed corners plus seeded random requests,
// compared cycle by cycle against a model written from the requirements.
module lsm_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] base_addr_i = '0;
    logic [15:0] reg_mask_i = '0;
    logic        is_load_i = 1'b0;
    logic        fwd_ok_i = 1'b0;
    logic        busy_o, beat_valid_o, beat_dword_o, beat_load_o;
    logic        done_o, err_o, first_ready_o;
    logic [31:0] beat_addr_o;
    logic [3:0]  beat_reg0_o, beat_reg1_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    lsm_seq u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .base_addr_i   (base_addr_i),
        .reg_mask_i    (reg_mask_i),
        .is_load_i     (is_load_i),
        .fwd_ok_i      (fwd_ok_i),
        .busy_o        (busy_o),
        .beat_valid_o  (beat_valid_o),
        .beat_addr_o   (beat_addr_o),
        .beat_dword_o  (beat_dword_o),
        .beat_reg0_o   (beat_reg0_o),
        .beat_reg1_o   (beat_reg1_o),
        .beat_load_o   (beat_load_o),
        .done_o        (done_o),
        .err_o         (err_o),
        .first_ready_o (first_ready_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == WATCHDOG) begin
            errors = errors + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int beats_for(input logic [31:0] base, input int n);
        if (n == 0) return 0;
        if (base[2] == 1'b0) return (n + 1) / 2;
        return n / 2 + 1;
    endfunction

    // Issue one request and check every cycle until it has settled.
    task automatic run_op(input logic [31:0] base, input logic [15:0] mask,
                          input logic ld, input logic fw, input bit poke);
        int n, nexp, lat, beats, seen, i0, i1;
        logic [15:0] rem;
        logic [31:0] a;
        logic pair;
        string ctag;
        n = $countones(mask);
        nexp = beats_for(base, n);
        lat = fw ? 2 : 3;
        ctag = (n == 1) ? "R11" : (base[2] ? "R4" : "R3");
        @(negedge clk);
        start_i = 1'b1; base_addr_i = base; reg_mask_i = mask;
        is_load_i = ld; fwd_ok_i = fw;
        @(negedge clk);
        start_i = 1'b0;
        rem = mask; a = base; beats = 0; seen = 0;
        for (int k = 0; k < 24; k++) begin
            seen += busy_o ? 1 : 0;
            if (rem != 0) begin
                i0 = -1; i1 = -1;
                for (int b = 0; b < 16; b++) begin
                    if (rem[b]) begin
                        if (i0 < 0) i0 = b;
                        else if (i1 < 0) i1 = b;
                    end
                end
                pair = (a[2:0] == 3'b000) && (i1 >= 0);
                chk("R7 busy on beat", busy_o, 1);
                chk("R7 valid on beat", beat_valid_o, 1);
                chk("R5 beat address", beat_addr_o, a);
                chk((base[2] && beats == 0) ? "R4 first beat word" : "R2 beat size", beat_dword_o, pair);
                chk("R2 lower register", beat_reg0_o, i0);
                chk("R2 upper register", beat_reg1_o, pair ? i1 : 0);
                chk("R6 direction", beat_load_o, ld);
                chk("R7 no done on beat", done_o, 0);
                rem[i0] = 1'b0;
                if (pair) rem[i1] = 1'b0;
                a = a + (pair ? 8 : 4);
                beats++;
                if (poke && ($urandom % 2 == 1)) begin
                    // R8: a start during busy must change nothing.
                    start_i = 1'b1;
                    base_addr_i = $urandom & 32'hFFFF_FFFC;
                    reg_mask_i = $urandom;
                    is_load_i = ~ld;
                    fwd_ok_i = $urandom;
                end else begin
                    start_i = 1'b0;
                end
            end else begin
                start_i = 1'b0;
                chk("R7 busy after last beat", busy_o, 0);
                chk(n == 0 ? "R9 done on empty mask" : "R7 done pulse", done_o, (k == beats));
                chk("R9 error flag", err_o, (n == 0 && k == 0));
            end
            chk("R10 first ready", first_ready_o, (ld && n != 0 && k == lat));
            if (rem == 0 && k > beats && k >= 3) break;
            @(negedge clk);
        end
        chk({ctag, " beat count"}, seen, nexp);
    endtask

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 busy in reset", busy_o, 0);
        chk("R1 done in reset", done_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy after reset", busy_o, 0);
        chk("R1 valid after reset", beat_valid_o, 0);
        chk("R1 done after reset", done_o, 0);
        chk("R1 err after reset", err_o, 0);
        chk("R1 ready after reset", first_ready_o, 0);

        // R11 single register, both alignments
        run_op(32'h0000_1000, 16'h0020, 1'b1, 1'b1, 1'b0);
        run_op(32'h0000_1004, 16'h8000, 1'b1, 1'b0, 1'b0);
        // R3 aligned 3 and 16 registers
        run_op(32'h0000_2000, 16'h0007, 1'b1, 1'b1, 1'b0);
        run_op(32'h0000_2008, 16'hFFFF, 1'b1, 1'b0, 1'b0);
        // R4 unaligned 2 and 16 registers
        run_op(32'h0000_3004, 16'h0003, 1'b1, 1'b1, 1'b0);
        run_op(32'h0000_300C, 16'hFFFF, 1'b1, 1'b0, 1'b0);
        // R6 stores with the same shapes
        run_op(32'h0000_2008, 16'hFFFF, 1'b0, 1'b1, 1'b0);
        run_op(32'h0000_300C, 16'hA5A5, 1'b0, 1'b0, 1'b0);
        // R9 empty mask, load and store
        run_op(32'h0000_4000, 16'h0000, 1'b1, 1'b1, 1'b0);
        run_op(32'h0000_4004, 16'h0000, 1'b0, 1'b0, 1'b0);
        // R2 sparse mask with gaps and R8 pokes
        run_op(32'h0000_5000, 16'h8421, 1'b1, 1'b1, 1'b1);
        run_op(32'hFFFF_FFF4, 16'h0F0F, 1'b1, 1'b0, 1'b1);

        for (int r = 0; r < 400; r++) begin
            logic [15:0] m;
            m = $urandom;
            if (r % 4 == 1) m = m & $urandom & $urandom;
            if (r % 23 == 0) m = 16'h0000;
            run_op($urandom & 32'hFFFF_FFFC, m, $urandom, $urandom, 1'b1);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule